// File: doc/BRIEF.md
# Load-Store Ordering Guard with Store-Wait Learning

This block decides whether a load that wants to issue may run ahead of the uncommitted stores that come before it in program order. It also catches the cases where such a load ran too early. Memory operations are entered into a small ring in program order as they are decoded. Stores later report their addresses. Loads ask for permission to execute, and the oldest entry leaves the ring when it commits. All address comparisons look only at the low twelve bits of the address. The check is therefore conservative: two different addresses that share these bits are treated as a conflict.

The block has two modes. In the cautious mode a load never passes a store whose address is still unknown. In the speculative mode it may. If that store then resolves to the address of a younger load that has already executed, the block signals a squash for the oldest such load in the same cycle. At the next clock edge it drops that load and everything younger from the ring. A 64-entry table of one-bit flags, indexed by the low six bits of the load's PC, remembers which loads caused a squash. A flagged load waits until no older store is left in the ring. A free-running counter wipes the whole table every 4096 cycles, so stale flags do not throttle loads forever.

Top module: `ldst_order_guard`

## Requirements
- R1: After reset the ring is empty (`occupancy` = 0, `alloc_ready` = 1) and every store-wait flag is clear. With an empty ring no load is granted and no squash is raised.
- R2: An allocation takes the slot shown on `alloc_idx` in that cycle. Slots are handed out in ring order starting at 0 after reset. A commit removes the oldest entry. When 16 entries are held, `alloc_ready` is 0 and further allocations are ignored.
- R3: With `predict_en` = 0, a load is not granted while any older store in the ring has no address yet.
- R4: In either mode, a load is not granted while an older store with a known address has the same low 12 address bits as the load, whatever the upper bits are. Stores whose low 12 bits differ do not block.
- R5: With `predict_en` = 1, older stores whose addresses are unknown do not block a load.
- R6: When a store's address resolves and its low 12 bits match those of a younger load that has already executed, `squash_valid` is 1 in that same cycle and `squash_idx` names that load's slot.
- R7: At the edge that ends a squash cycle, the squashed load and every younger entry leave the ring. An allocation presented in that cycle is dropped, so the next allocation reuses the squashed slot.
- R8: A squash sets the store-wait flag selected by bits [5:0] of the squashed load's PC. In either mode, a load whose flag is set is not granted while any older store remains in the ring. It is granted once none remain.
- R9: When several executed younger loads match the resolving store, the squash names the oldest of them.
- R10: A store address that resolves in the same cycle as a younger load issues is already counted as known by that load's check. A match blocks the grant, and no squash follows.
- R11: A load that is issued in a squash cycle and sits at or after the squashed slot is not granted.
- R12: Every store-wait flag is cleared at each 4096th clock edge after reset is released.
- R13: When a squash and the periodic clear fall on the same edge, the flag set by the squash survives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| predict_en | input | 1 | 1: loads may pass stores whose address is unknown; 0: they may not |
| alloc_valid | input | 1 | Enter a new memory operation at the young end of the ring |
| alloc_store | input | 1 | New operation is a store (1) or a load (0) |
| alloc_pc | input | 32 | PC of the new operation; bits [5:0] select its store-wait flag |
| alloc_ready | output | 1 | Ring has a free slot |
| alloc_idx | output | 4 | Slot the allocation of this cycle receives |
| commit_valid | input | 1 | Retire the oldest entry |
| sta_valid | input | 1 | A store's address is resolved this cycle |
| sta_idx | input | 4 | Slot of that store |
| sta_addr | input | 32 | Resolved store address |
| ld_valid | input | 1 | A load asks to execute this cycle |
| ld_idx | input | 4 | Slot of that load |
| ld_addr | input | 32 | Load address |
| ld_grant | output | 1 | Load may execute; it is marked executed at the edge |
| squash_valid | output | 1 | Ordering violation detected this cycle |
| squash_idx | output | 4 | Slot of the oldest violating load |
| occupancy | output | 5 | Number of entries held in the ring |

## Verification
Two pairs of functions are provoked in the same cycle. In the first, a store resolves while a younger load asks to execute. Either a matching address must block the grant with no squash (R10), or a squash already raised for an older load must refuse the younger request (R11). The second pair is a squash landing on the very edge of the periodic flag wipe. The bench counts edges since reset and places the store resolution exactly in the cycle before that edge. It then judges the outcome by re-issuing the same load PC behind an older store and seeing its grant withheld (R13).

// File: rtl/ldst_order_pkg.sv
package ldst_order_pkg;

    // Low address bits used for every store/load comparison.
    localparam int CMP_W    = 12;
    // Index width of the store-wait flag table.
    localparam int WT_IDX_W = 6;

    typedef struct packed {
        logic                is_st;  // entry is a store
        logic                a_ok;   // address known (store) / recorded (load)
        logic                exec;   // load has executed
        logic [CMP_W-1:0]    a_lo;   // low address bits
        logic [WT_IDX_W-1:0] wt;     // store-wait flag index taken from PC
    } slot_t;

    function automatic slot_t slot_new(input logic is_st,
                                       input logic [WT_IDX_W-1:0] wt);
        slot_t s;
        s       = '0;
        s.is_st = is_st;
        s.wt    = wt;
        return s;
    endfunction

endpackage

// File: rtl/ldst_ring.sv
module ldst_ring
    import ldst_order_pkg::*;
#(
    parameter  int QDEPTH = 16,
    localparam int IDX_W  = $clog2(QDEPTH)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     push,
    input  slot_t                    push_slot,
    input  logic                     pop,
    input  logic                     sta_wr,
    input  logic [IDX_W-1:0]         sta_idx,
    input  logic [CMP_W-1:0]         sta_lo,
    input  logic                     ld_wr,
    input  logic [IDX_W-1:0]         ld_idx,
    input  logic [CMP_W-1:0]         ld_lo,
    input  logic                     trunc,
    input  logic [IDX_W-1:0]         trunc_off,
    output slot_t [QDEPTH-1:0]       slots,
    output logic [IDX_W-1:0]         head,
    output logic [IDX_W:0]           count
);

    logic [IDX_W-1:0] tail;
    logic [IDX_W:0]   base;

    assign tail = head + count[IDX_W-1:0];
    assign base = trunc ? {1'b0, trunc_off} : count + (IDX_W+1)'(push);

    always_ff @(posedge clk) begin
        if (rst) begin
            slots <= '0;
            head  <= '0;
            count <= '0;
        end else begin
            if (sta_wr) begin
                slots[sta_idx].a_ok <= 1'b1;
                slots[sta_idx].a_lo <= sta_lo;
            end
            if (ld_wr) begin
                slots[ld_idx].a_ok <= 1'b1;
                slots[ld_idx].exec <= 1'b1;
                slots[ld_idx].a_lo <= ld_lo;
            end
            if (push)
                slots[tail] <= push_slot;
            if (pop)
                head <= head + 1'b1;
            count <= base - (IDX_W+1)'(pop);
        end
    end

endmodule

// File: rtl/ldst_scan.sv
module ldst_scan
    import ldst_order_pkg::*;
#(
    parameter  int QDEPTH = 16,
    localparam int IDX_W  = $clog2(QDEPTH)
) (
    input  slot_t [QDEPTH-1:0] slots,
    input  logic [IDX_W-1:0]   head,
    input  logic [IDX_W:0]     count,
    input  logic               predict_en,
    input  logic               sta_valid,
    input  logic [IDX_W-1:0]   sta_idx,
    input  logic [CMP_W-1:0]   sta_lo,
    input  logic               ld_valid,
    input  logic [IDX_W-1:0]   ld_idx,
    input  logic [CMP_W-1:0]   ld_lo,
    input  logic               ld_wait,
    output logic               grant,
    output logic               viol,
    output logic [IDX_W-1:0]   viol_off
);

    logic [IDX_W-1:0] ld_off, sta_off;
    logic             old_any, old_unk, old_hit;
    logic             unused_wt;

    assign ld_off  = ld_idx - head;
    assign sta_off = sta_idx - head;

    // Oldest executed younger load matching the resolving store.
    always_comb begin
        viol     = 1'b0;
        viol_off = '0;
        for (int k = QDEPTH - 1; k >= 1; k--) begin
            if (sta_valid && IDX_W'(k) > sta_off && (IDX_W+1)'(k) < count
                && !slots[head + IDX_W'(k)].is_st
                && slots[head + IDX_W'(k)].exec
                && slots[head + IDX_W'(k)].a_lo == sta_lo) begin
                viol     = 1'b1;
                viol_off = IDX_W'(k);
            end
        end
    end

    // Older stores seen by the issuing load; a same-cycle resolution counts as known.
    always_comb begin
        old_any   = 1'b0;
        old_unk   = 1'b0;
        old_hit   = 1'b0;
        unused_wt = 1'b0;
        for (int i = 0; i < QDEPTH; i++) begin
            unused_wt = unused_wt ^ (^slots[i].wt);
            if ({1'b0, IDX_W'(i) - head} < count && (IDX_W'(i) - head) < ld_off
                && slots[i].is_st) begin
                old_any = 1'b1;
                if (sta_valid && sta_idx == IDX_W'(i)) begin
                    if (sta_lo == ld_lo) old_hit = 1'b1;
                end else if (!slots[i].a_ok) begin
                    old_unk = 1'b1;
                end else if (slots[i].a_lo == ld_lo) begin
                    old_hit = 1'b1;
                end
            end
        end
    end

    assign grant = ld_valid && ({1'b0, ld_off} < count) && !slots[ld_idx].is_st
                && !old_hit && !(ld_wait && old_any) && (predict_en || !old_unk)
                && !(viol && ld_off >= viol_off);

endmodule

// File: rtl/ldst_wait_tbl.sv
module ldst_wait_tbl #(
    parameter  int WT_N   = 64,
    parameter  int PERIOD = 4096,
    localparam int WT_W   = $clog2(WT_N),
    localparam int CW     = $clog2(PERIOD)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            set_en,
    input  logic [WT_W-1:0] set_idx,
    output logic [WT_N-1:0] bits,
    output logic            clr_pulse
);

    logic [CW-1:0] cnt;

    assign clr_pulse = (cnt == CW'(PERIOD - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            bits <= '0;
        end else begin
            cnt <= clr_pulse ? '0 : cnt + 1'b1;
            if (clr_pulse)
                bits <= '0;
            if (set_en)
                bits[set_idx] <= 1'b1;   // set beats the periodic wipe
        end
    end

endmodule

// File: rtl/ldst_order_guard.sv
module ldst_order_guard
    import ldst_order_pkg::*;
#(
    parameter  int QDEPTH     = 16,
    parameter  int ADDR_W     = 32,
    parameter  int PC_W       = 32,
    parameter  int CLR_PERIOD = 4096,
    localparam int IDX_W      = $clog2(QDEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              predict_en,
    input  logic              alloc_valid,
    input  logic              alloc_store,
    input  logic [PC_W-1:0]   alloc_pc,
    output logic              alloc_ready,
    output logic [IDX_W-1:0]  alloc_idx,
    input  logic              commit_valid,
    input  logic              sta_valid,
    input  logic [IDX_W-1:0]  sta_idx,
    input  logic [ADDR_W-1:0] sta_addr,
    input  logic              ld_valid,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic              ld_grant,
    output logic              squash_valid,
    output logic [IDX_W-1:0]  squash_idx,
    output logic [IDX_W:0]    occupancy
);

    localparam int WT_N = 1 << WT_IDX_W;

    slot_t [QDEPTH-1:0]  slots;
    logic [IDX_W-1:0]    head;
    logic [IDX_W:0]      count;
    logic [IDX_W-1:0]    viol_off;
    logic                push, pop, ld_wait;
    logic                wt_set, clr_pulse;
    logic [WT_IDX_W-1:0] wt_set_idx;
    logic [WT_N-1:0]     wt_bits;
    logic                unused_hi;

    assign unused_hi = ^{sta_addr[ADDR_W-1:CMP_W], ld_addr[ADDR_W-1:CMP_W],
                         alloc_pc[PC_W-1:WT_IDX_W]};

    assign occupancy   = count;
    assign alloc_ready = count < (IDX_W+1)'(QDEPTH);
    assign alloc_idx   = head + count[IDX_W-1:0];
    assign push        = alloc_valid && alloc_ready && !squash_valid;
    assign pop         = commit_valid && count != '0;
    assign squash_idx  = head + viol_off;
    assign ld_wait     = wt_bits[slots[ld_idx].wt];
    assign wt_set      = squash_valid;
    assign wt_set_idx  = slots[squash_idx].wt;

    ldst_ring #(.QDEPTH(QDEPTH)) u_ring (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_slot (slot_new(alloc_store, alloc_pc[WT_IDX_W-1:0])),
        .pop       (pop),
        .sta_wr    (sta_valid),
        .sta_idx   (sta_idx),
        .sta_lo    (sta_addr[CMP_W-1:0]),
        .ld_wr     (ld_grant),
        .ld_idx    (ld_idx),
        .ld_lo     (ld_addr[CMP_W-1:0]),
        .trunc     (squash_valid),
        .trunc_off (viol_off),
        .slots     (slots),
        .head      (head),
        .count     (count)
    );

    ldst_scan #(.QDEPTH(QDEPTH)) u_scan (
        .slots      (slots),
        .head       (head),
        .count      (count),
        .predict_en (predict_en),
        .sta_valid  (sta_valid),
        .sta_idx    (sta_idx),
        .sta_lo     (sta_addr[CMP_W-1:0]),
        .ld_valid   (ld_valid),
        .ld_idx     (ld_idx),
        .ld_lo      (ld_addr[CMP_W-1:0]),
        .ld_wait    (ld_wait),
        .grant      (ld_grant),
        .viol       (squash_valid),
        .viol_off   (viol_off)
    );

    ldst_wait_tbl #(.WT_N(WT_N), .PERIOD(CLR_PERIOD)) u_wait (
        .clk       (clk),
        .rst       (rst),
        .set_en    (wt_set),
        .set_idx   (wt_set_idx),
        .bits      (wt_bits),
        .clr_pulse (clr_pulse)
    );

endmodule

// File: rtl/ldst_order_guard_chk.sv
module ldst_order_guard_chk #(
    parameter  int QDEPTH = 16,
    parameter  int WT_N   = 64,
    localparam int IDX_W  = $clog2(QDEPTH),
    localparam int WT_W   = $clog2(WT_N)
) (
    input logic             clk,
    input logic             rst,
    input logic             alloc_valid,
    input logic             alloc_ready,
    input logic             commit_valid,
    input logic [IDX_W:0]   occupancy,
    input logic             ld_valid,
    input logic [IDX_W-1:0] ld_idx,
    input logic             ld_grant,
    input logic             squash_valid,
    input logic [IDX_W-1:0] squash_idx,
    input logic             wt_set,
    input logic [WT_W-1:0]  wt_set_idx,
    input logic [WT_N-1:0]  wt_bits,
    input logic             clr_pulse
);

    // R1: an empty ring neither grants nor squashes
    p_empty_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (occupancy == '0) |-> (!ld_grant && !squash_valid));

    // R2: allocation into a full ring changes nothing
    p_full_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (alloc_valid && !alloc_ready && !commit_valid && !squash_valid)
        |=> (occupancy == $past(occupancy)));

    // R7: a squash always removes at least the squashed load
    p_flush_shrinks_r7: assert property (@(posedge clk) disable iff (rst)
        squash_valid |=> (occupancy < $past(occupancy)));

    // R11: the squashed slot is never granted in the squash cycle
    p_squash_blocks_r11: assert property (@(posedge clk) disable iff (rst)
        (squash_valid && ld_valid && ld_idx == squash_idx) |-> !ld_grant);

    // R12: a wipe without a concurrent set leaves no flag
    p_wipe_all_r12: assert property (@(posedge clk) disable iff (rst)
        (clr_pulse && !wt_set) |=> (wt_bits == '0));

    // R8, R13: a squash leaves its flag set, even across a wipe
    p_set_wins_r13: assert property (@(posedge clk) disable iff (rst)
        wt_set |=> wt_bits[$past(wt_set_idx)]);

endmodule

bind ldst_order_guard ldst_order_guard_chk #(
    .QDEPTH (QDEPTH),
    .WT_N   (WT_N)
) chk_i (
    .clk          (clk),
    .rst          (rst),
    .alloc_valid  (alloc_valid),
    .alloc_ready  (alloc_ready),
    .commit_valid (commit_valid),
    .occupancy    (occupancy),
    .ld_valid     (ld_valid),
    .ld_idx       (ld_idx),
    .ld_grant     (ld_grant),
    .squash_valid (squash_valid),
    .squash_idx   (squash_idx),
    .wt_set       (wt_set),
    .wt_set_idx   (wt_set_idx),
    .wt_bits      (wt_bits),
    .clr_pulse    (clr_pulse)
);

// File: tb/ldst_order_guard_tb_top.sv
module ldst_order_guard_tb_top;

    localparam int PERIOD_CLR = 4096;

    logic        clk = 1'b0;
    logic        rst, predict_en;
    logic        alloc_valid, alloc_store;
    logic [31:0] alloc_pc;
    logic        alloc_ready;
    logic [3:0]  alloc_idx;
    logic        commit_valid;
    logic        sta_valid;
    logic [3:0]  sta_idx;
    logic [31:0] sta_addr;
    logic        ld_valid;
    logic [3:0]  ld_idx;
    logic [31:0] ld_addr;
    logic        ld_grant, squash_valid;
    logic [3:0]  squash_idx;
    logic [4:0]  occupancy;

    int errors = 0;
    int checks = 0;
    int ecyc   = 0;
    bit done   = 0;

    typedef struct { int idx; string tag; } sq_item_t;
    sq_item_t sq_q[$];

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (rst) ecyc <= 0;
        else     ecyc <= ecyc + 1;
    end

    ldst_order_guard dut_i (
        .clk(clk), .rst(rst), .predict_en(predict_en),
        .alloc_valid(alloc_valid), .alloc_store(alloc_store), .alloc_pc(alloc_pc),
        .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
        .commit_valid(commit_valid),
        .sta_valid(sta_valid), .sta_idx(sta_idx), .sta_addr(sta_addr),
        .ld_valid(ld_valid), .ld_idx(ld_idx), .ld_addr(ld_addr),
        .ld_grant(ld_grant), .squash_valid(squash_valid), .squash_idx(squash_idx),
        .occupancy(occupancy)
    );

    task automatic check_eq(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: every squash must match the next expected scoreboard item.
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (!rst && squash_valid) begin
                checks++;
                if (sq_q.size() == 0) begin
                    errors++;
                    $display("FAIL R6 unexpected squash: actual idx=%0d expected none", squash_idx);
                end else begin
                    sq_item_t it;
                    it = sq_q.pop_front();
                    if (int'(squash_idx) != it.idx) begin
                        errors++;
                        $display("FAIL %s squash idx: actual=%0d expected=%0d",
                                 it.tag, squash_idx, it.idx);
                    end
                end
            end
        end
    end

    task automatic tick();
        @(negedge clk);
        alloc_valid  = 0;
        commit_valid = 0;
        sta_valid    = 0;
        ld_valid     = 0;
    endtask

    task automatic do_reset(bit pred);
        rst = 1; predict_en = pred;
        alloc_valid = 0; alloc_store = 0; alloc_pc = 0; commit_valid = 0;
        sta_valid = 0; sta_idx = 0; sta_addr = 0;
        ld_valid = 0; ld_idx = 0; ld_addr = 0;
        repeat (2) @(negedge clk);
        rst = 0;
    endtask

    task automatic do_alloc(bit st, logic [31:0] pc, int exp_idx, string tag);
        alloc_valid = 1; alloc_store = st; alloc_pc = pc;
        #2 check_eq({tag, " alloc_idx"}, alloc_idx, exp_idx);
        tick();
    endtask

    task automatic do_load(int idx, logic [31:0] a, bit exp, string tag);
        ld_valid = 1; ld_idx = 4'(idx); ld_addr = a;
        #2 check_eq({tag, " ld_grant"}, ld_grant, exp);
        tick();
    endtask

    task automatic do_sta(int idx, logic [31:0] a, int exp_sq, string tag);
        if (exp_sq >= 0) sq_q.push_back('{idx: exp_sq, tag: tag});
        sta_valid = 1; sta_idx = 4'(idx); sta_addr = a;
        #2 check_eq({tag, " squash_valid"}, squash_valid, exp_sq >= 0);
        tick();
    endtask

    task automatic do_commit();
        commit_valid = 1;
        tick();
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        do_reset(0);
        #2;
        check_eq("R1 occupancy", occupancy, 0);
        check_eq("R1 alloc_ready", alloc_ready, 1);
        check_eq("R1 squash", squash_valid, 0);
        tick();
        do_load(0, 32'h0, 0, "R1 empty ring");

        // R2: fill and overflow
        for (int i = 0; i < 16; i++) do_alloc(1, 32'h0, i, "R2");
        check_eq("R2 full ready", alloc_ready, 0);
        alloc_valid = 1; alloc_store = 0;
        tick();
        check_eq("R2 overflow ignored", occupancy, 16);
        do_commit();
        check_eq("R2 commit pops", occupancy, 15);

        // R3 / R4: cautious mode
        do_reset(0);
        do_alloc(1, 32'h10, 0, "R2 store slot");
        do_alloc(0, 32'h21, 1, "R2 load slot");
        do_load(1, 32'h2004, 0, "R3 unknown store blocks");
        do_sta(0, 32'h0000_1000, -1, "R3 resolve");
        do_load(1, 32'h2004, 1, "R4 low bits differ");
        do_alloc(0, 32'h22, 2, "R2 next slot");
        do_load(2, 32'hABCD_E000, 0, "R4 partial match blocks");
        do_commit();
        check_eq("R2 after commit", occupancy, 2);
        do_load(2, 32'hABCD_E000, 1, "R4 store gone");

        // R5..R8: speculative mode, squash and learning
        do_reset(1);
        do_alloc(1, 32'h30, 0, "R5 store");
        do_alloc(0, 32'h05, 1, "R5 load");
        do_load(1, 32'h7654_3ABC, 1, "R5 passes unknown store");
        do_alloc(0, 32'h07, 2, "R7 younger load");
        sq_q.push_back('{idx: 1, tag: "R6"});
        sta_valid = 1; sta_idx = 0; sta_addr = 32'h0000_0ABC;
        alloc_valid = 1; alloc_store = 0; alloc_pc = 32'h09;
        #2 check_eq("R6 squash_valid", squash_valid, 1);
        check_eq("R6 squash_idx", squash_idx, 1);
        tick();
        check_eq("R7 flush occupancy", occupancy, 1);
        do_alloc(0, 32'h05, 1, "R7 slot reused");
        do_load(1, 32'h0000_0FFF, 0, "R8 flagged load waits");
        do_commit();
        do_load(1, 32'h0000_0FFF, 1, "R8 granted when no older store");

        // R9: oldest violator
        do_reset(1);
        do_alloc(1, 32'h0, 0, "R9 store");
        do_alloc(0, 32'h11, 1, "R9 load a");
        do_alloc(0, 32'h12, 2, "R9 load b");
        do_alloc(0, 32'h13, 3, "R9 load c");
        do_load(1, 32'h0000_0123, 1, "R9 load a exec");
        do_load(2, 32'h0000_5123, 1, "R9 load b exec");
        do_load(3, 32'h0000_0456, 1, "R9 load c exec");
        do_sta(0, 32'h0000_9123, 1, "R9");
        check_eq("R9 occupancy after flush", occupancy, 1);

        // R11: younger load issuing in a squash cycle
        do_reset(1);
        do_alloc(1, 32'h0, 0, "R11 store");
        do_alloc(0, 32'h15, 1, "R11 load a");
        do_alloc(0, 32'h16, 2, "R11 load b");
        do_load(1, 32'h0000_0888, 1, "R11 load a exec");
        sq_q.push_back('{idx: 1, tag: "R11"});
        sta_valid = 1; sta_idx = 0; sta_addr = 32'h0000_0888;
        ld_valid = 1; ld_idx = 2; ld_addr = 32'h0000_0333;
        #2 check_eq("R11 younger grant", ld_grant, 0);
        tick();

        // R10: resolution and issue in the same cycle
        do_reset(1);
        do_alloc(1, 32'h0, 0, "R10 store");
        do_alloc(0, 32'h17, 1, "R10 load");
        sta_valid = 1; sta_idx = 0; sta_addr = 32'h0000_0444;
        ld_valid = 1; ld_idx = 1; ld_addr = 32'h0000_1444;
        #2 check_eq("R10 same-cycle grant", ld_grant, 0);
        check_eq("R10 no squash", squash_valid, 0);
        tick();
        do_load(1, 32'h0000_0445, 1, "R10 no flag learnt");

        // R12: periodic wipe
        do_reset(1);
        do_alloc(1, 32'h0, 0, "R12 store");
        do_alloc(0, 32'h05, 1, "R12 load");
        do_load(1, 32'h0000_0100, 1, "R12 load exec");
        do_sta(0, 32'h0000_0100, 1, "R12 squash");
        do_alloc(0, 32'h05, 1, "R12 realloc");
        do_load(1, 32'h0000_0200, 0, "R12 flag set");
        while ((ecyc % PERIOD_CLR) != PERIOD_CLR - 1) @(negedge clk);
        do_load(1, 32'h0000_0200, 0, "R12 not wiped early");
        do_load(1, 32'h0000_0200, 1, "R12 wiped");

        // R13: squash on the wipe edge
        do_reset(1);
        do_alloc(1, 32'h0, 0, "R13 store");
        do_alloc(0, 32'h2A, 1, "R13 load");
        do_load(1, 32'h0000_0077, 1, "R13 load exec");
        while ((ecyc % PERIOD_CLR) != PERIOD_CLR - 1) @(negedge clk);
        do_sta(0, 32'h0000_0077, 1, "R13 squash");
        do_alloc(0, 32'h2A, 1, "R13 realloc");
        do_load(1, 32'h0000_0099, 0, "R13 flag survived");

        repeat (2) @(negedge clk);
        check_eq("R6 scoreboard drained", sq_q.size(), 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule